// File: doc/BRIEF.md
# Fixed-Vector Priority Interrupt Controller

This block gathers sixteen interrupt bit positions (fifteen live sources plus one reserved slot) coming from display timing, timers, sound, DMA, controller and expansion-bus logic. It turns each rising edge into a sticky pending bit. It then offers the host processor exactly one request at a time, together with that source's fixed priority level and exception vector. Software controls the block through two 32-bit registers on a simple register bus: an enable mask and a pending-status register. A status read returns the inverted pending image. A status write loads the pending bits directly.

Presentation is run by a two-state machine. In `ST_IDLE` no request is driven. The transition `IDLE_TO_PRESENT` happens when at least one pending, enabled source exists: the winner is captured and `irq_req` is raised. In `ST_PRESENT` the captured level and vector are held. There are two ways out. `PRESENT_TO_IDLE_ACK` is taken on `irq_ack` and clears the winner's pending bit. `PRESENT_TO_IDLE_WITHDRAW` is taken when the captured source is no longer both pending and enabled. The machine always spends at least one cycle in `ST_IDLE` between two presentations.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, every pending bit is 0 (a status read returns 0xFFFFFFFF) and the mask register reads 0x0000FFFF.
- R2: A 0-to-1 transition on `src_i[n]` sets pending bit n at the next clock edge. A source held high does not set its bit again after it has been cleared.
- R3: Bit n has this fixed level and vector: 0: 15/0x40; 1: 14/0x41; 2: 13/0x42; 3: 12/0x43; 4: 11/0x44; 5: 10/0x45; 6: 9/0x46; 7: 8/0x47; 8: 8/0x48; 9: 5/0x4B; 10: 6/0x4A; 11: 6/0x49; 12: 3/0x4C; 13: 2/0x4D; 15: 7/0x50. A presented request never has level 0.
- R4: Mask bit n = 1 disables source n (n ≠ 7). An edge that arrives while the source is disabled is still latched. It is presented once the mask bit is cleared.
- R5: Mask bit 7 has inverted sense: 1 enables source 7 and 0 disables it.
- R6: A status read (`reg_sel`=1) returns the bitwise complement of the 16 pending bits zero-extended to 32 bits, so bits 31:16 read 1. A mask read (`reg_sel`=0) returns the 16 mask bits zero-extended.
- R7: A status write loads `reg_wdata[15:0]` into the pending bits. That cycle it overrides any source edge, pad-latch event or acknowledge.
- R8: Among pending enabled sources the highest level is presented. On equal levels the lower bit index wins.
- R9: `irq_ack` while `irq_req` is high clears the presented source's pending bit. `irq_req` is low in the next cycle, and the next winner, if any, is presented the cycle after.
- R10: While a request is presented its level and vector stay fixed even if a higher-level source becomes pending. If the presented source is disabled or its pending bit is cleared, the request is withdrawn one cycle later.
- R11: A pad-latch write (`pad_latch_wr`=1) with either bit of `pad_latch_en` set sets pending bit 8. With both bits 0 it has no effect.
- R12: Bit 14 is reserved: its source input and status-write bit are ignored, and it always reads back as pending-clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 16 | Interrupt source lines, rising-edge sensitive |
| pad_latch_wr | input | 1 | Strobe of a controller-port latch enable write |
| pad_latch_en | input | 2 | Latch enable bits for the two controller ports |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects mask register, 1 selects status register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_sel`) |
| irq_ack | input | 1 | One-cycle acknowledge from the host |
| irq_req | output | 1 | Request to the host |
| irq_level | output | 4 | Priority level of the presented request |
| irq_vector | output | 8 | Exception vector of the presented request |

## Verification
The bench walks every live source alone through edge, presentation, acknowledge and clear. This catches a wrong table entry or a swapped DMA vector. It then loads every pair of sources through the status register. A comparator with its tie rule reversed would hand the level-6 and level-8 pairs to the higher bit. The inverted enable of bit 7 is tested in both senses, because a design that treats it like the others would present the system-manager source while it should be blocked. The bench also probes the cases of a held-high source, a masked-then-unmasked source and a withdrawn presentation, and confirms that status writes win over same-cycle edges. A design that re-arms on level, drops masked edges, or lets a higher source replace the one being presented fails at once.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_SRC    = 16;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int LVL_W      = 4;
    localparam int VEC_W      = 8;
    localparam int SYS_BIT    = 7;
    localparam int PAD_BIT    = 8;
    localparam int UNUSED_BIT = 14;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } present_state_e;

    // Fixed priority level of each bit position.
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        case (idx)
            0:       src_level = 4'd15;
            1:       src_level = 4'd14;
            2:       src_level = 4'd13;
            3:       src_level = 4'd12;
            4:       src_level = 4'd11;
            5:       src_level = 4'd10;
            6:       src_level = 4'd9;
            7, 8:    src_level = 4'd8;
            9:       src_level = 4'd5;
            10, 11:  src_level = 4'd6;
            12:      src_level = 4'd3;
            13:      src_level = 4'd2;
            15:      src_level = 4'd7;
            default: src_level = 4'd0;
        endcase
    endfunction

    // Fixed exception vector of each bit position.
    function automatic logic [VEC_W-1:0] src_vector(input int idx);
        case (idx)
            9:       src_vector = 8'h4B;
            10:      src_vector = 8'h4A;
            11:      src_vector = 8'h49;
            15:      src_vector = 8'h50;
            14:      src_vector = 8'h00;
            default: src_vector = 8'h40 + 8'(idx);
        endcase
    endfunction

endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
    import irq_vec_pkg::*;
#(
    parameter int NSRC  = NUM_SRC,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             pad_wr,
    input  logic [1:0]       pad_en,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [NSRC-1:0]  ack_clr,
    output logic [NSRC-1:0]  pend_o,
    output logic [NSRC-1:0]  enable_o,
    output logic [REG_W-1:0] rdata_o
);
    localparam logic [NSRC-1:0] LIVE    = ~(NSRC'(1) << UNUSED_BIT);
    localparam logic [NSRC-1:0] PAD_ONE = NSRC'(1) << PAD_BIT;

    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] set_v;

    assign set_v = ((src_i & ~src_q) | ((pad_wr && (|pad_en)) ? PAD_ONE : '0)) & LIVE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            src_q <= src_i;
            if (reg_wr && reg_sel)
                pend_q <= reg_wdata[NSRC-1:0] & LIVE;
            else
                pend_q <= (pend_q | set_v) & ~ack_clr;
            if (reg_wr && !reg_sel)
                mask_q <= reg_wdata[NSRC-1:0];
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_en
        if (g == SYS_BIT) begin : g_inv
            assign enable_o[g] = mask_q[g];
        end else if (g == UNUSED_BIT) begin : g_off
            assign enable_o[g] = 1'b0;
        end else begin : g_norm
            assign enable_o[g] = ~mask_q[g];
        end
    end

    assign pend_o  = pend_q;
    assign rdata_o = reg_sel ? ~REG_W'(pend_q) : REG_W'(mask_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int IW   = IDX_W
) (
    input  logic [NSRC-1:0] cand_i,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o
);
    logic [LVL_W-1:0] best_lvl;

    // Scan from the top index down with >=, so a lower index takes ties.
    always_comb begin
        valid_o  = 1'b0;
        idx_o    = '0;
        best_lvl = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand_i[i] && (!valid_o || src_level(i) >= best_lvl)) begin
                valid_o  = 1'b1;
                idx_o    = IW'(i);
                best_lvl = src_level(i);
            end
        end
    end

endmodule

// File: rtl/irq_present_fsm.sv
module irq_present_fsm
    import irq_vec_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int IW   = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_valid,
    input  logic [IW-1:0]    pick_idx,
    input  logic [NSRC-1:0]  pend_i,
    input  logic [NSRC-1:0]  enable_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [LVL_W-1:0] level_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [NSRC-1:0]  ack_clr_o
);
    present_state_e   state_q, state_d;
    logic [IW-1:0]    cur_q;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic             cur_live;

    assign cur_live = pend_i[cur_q] & enable_i[cur_q];

    // State register and captured winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            lvl_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_valid) begin
                cur_q <= pick_idx;
                lvl_q <= src_level(int'(pick_idx));
                vec_q <= src_vector(int'(pick_idx));
            end
        end
    end

    // Transitions: IDLE_TO_PRESENT, PRESENT_TO_IDLE_ACK, PRESENT_TO_IDLE_WITHDRAW.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pick_valid) state_d = ST_PRESENT;
            ST_PRESENT: if (ack_i || !cur_live) state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_o     = (state_q == ST_PRESENT);
        level_o   = req_o ? lvl_q : '0;
        vector_o  = req_o ? vec_q : '0;
        ack_clr_o = (req_o && ack_i) ? (NSRC'(1) << cur_q) : '0;
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] src_i,
    input  logic        pad_latch_wr,
    input  logic [1:0]  pad_latch_en,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        irq_ack,
    output logic        irq_req,
    output logic [3:0]  irq_level,
    output logic [7:0]  irq_vector
);
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] clr_w;
    logic               pick_v;
    logic [IDX_W-1:0]   pick_i;

    irq_pending_bank #(.NSRC(NUM_SRC), .REG_W(32)) bank_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .pad_wr(pad_latch_wr), .pad_en(pad_latch_en),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ack_clr(clr_w), .pend_o(pend_w), .enable_o(en_w), .rdata_o(reg_rdata)
    );

    irq_prio_pick #(.NSRC(NUM_SRC), .IW(IDX_W)) pick_u (
        .cand_i(pend_w & en_w), .valid_o(pick_v), .idx_o(pick_i)
    );

    irq_present_fsm #(.NSRC(NUM_SRC), .IW(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .pick_valid(pick_v), .pick_idx(pick_i),
        .pend_i(pend_w), .enable_i(en_w), .ack_i(irq_ack),
        .req_o(irq_req), .level_o(irq_level), .vector_o(irq_vector),
        .ack_clr_o(clr_w)
    );

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_req,
    input logic        irq_ack,
    input logic [3:0]  irq_level,
    input logic [7:0]  irq_vector,
    input logic [15:0] pend
);
    assert_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (!irq_req || ($stable(irq_vector) && $stable(irq_level))));

    assert_rise_from_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(|pend));

    assert_level_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != 4'd0 && (irq_vector[7:4] == 4'h4 || irq_vector[7:4] == 4'h5)));

    assert_reserved_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[14]);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_level(irq_level), .irq_vector(irq_vector), .pend(pend_w)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_i = '0;
    logic        pad_latch_wr = 1'b0;
    logic [1:0]  pad_latch_en = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .pad_latch_wr(pad_latch_wr), .pad_latch_en(pad_latch_en),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    function automatic int exp_lvl(input int i);
        if (i <= 6) return 15 - i;
        if (i <= 8) return 8;
        if (i == 9) return 5;
        if (i <= 11) return 6;
        if (i == 15) return 7;
        return 15 - i;
    endfunction

    function automatic int exp_vec(input int i);
        if (i >= 9 && i <= 11) return 'h54 - i;
        if (i == 15) return 'h50;
        return 'h40 + i;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int i);
        src_i[i] = 1'b1;
        tick(1);
        src_i[i] = 1'b0;
        tick(1);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    task automatic clean();
        wr(1'b1, 32'h0);
        tick(2);
    endtask

    initial begin
        logic [31:0] r;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 req", 32'(irq_req), 32'h0);
        rd(1'b1, r); check("R1 status", r, 32'hFFFF_FFFF);
        rd(1'b0, r); check("R1 mask", r, 32'h0000_FFFF);

        wr(1'b0, 32'h0080);  // everything enabled (bit 7 inverted)

        // R2 R3 R6 R9: each live source alone
        for (int i = 0; i < 16; i++) begin
            if (i == 14) continue;
            pulse(i);
            check("R3 req", 32'(irq_req), 32'h1);
            check("R3 level", 32'(irq_level), 32'(exp_lvl(i)));
            check("R3 vector", 32'(irq_vector), 32'(exp_vec(i)));
            rd(1'b1, r); check("R6 status", r, ~(32'h1 << i));
            ack();
            check("R9 drop", 32'(irq_req), 32'h0);
            rd(1'b1, r); check("R9 cleared", r, 32'hFFFF_FFFF);
            tick(1);
        end

        // R8 every pair via status write (R7)
        for (int i = 0; i < 16; i++) begin
            for (int j = i + 1; j < 16; j++) begin
                int w;
                if (i == 14 || j == 14) continue;
                w = (exp_lvl(j) > exp_lvl(i)) ? j : i;
                wr(1'b1, (32'h1 << i) | (32'h1 << j));
                tick(1);
                check("R8 winner", 32'(irq_vector), 32'(exp_vec(w)));
                clean();
            end
        end

        // R2 held-high source does not re-arm
        src_i[3] = 1'b1; tick(2);
        check("R2 first", 32'(irq_vector), 32'h43);
        ack(); tick(3);
        check("R2 no rearm", 32'(irq_req), 32'h0);
        src_i[3] = 1'b0; tick(1);

        // R4 masked edge latched, presented on unmask
        wr(1'b0, 32'h0081);
        pulse(0);
        check("R4 masked", 32'(irq_req), 32'h0);
        rd(1'b1, r); check("R4 latched", r, 32'hFFFF_FFFE);
        wr(1'b0, 32'h0080); tick(1);
        check("R4 unmasked", 32'(irq_vector), 32'h40);
        ack(); tick(1);

        // R5 inverted enable of bit 7
        wr(1'b0, 32'h0000);
        pulse(7);
        check("R5 blocked", 32'(irq_req), 32'h0);
        wr(1'b0, 32'h0080); tick(1);
        check("R5 enabled", 32'(irq_vector), 32'h47);
        ack(); tick(1);

        // R7 status write overrides same-cycle edge
        src_i[5] = 1'b1; wr(1'b1, 32'h0); src_i[5] = 1'b0; tick(1);
        check("R7 override", 32'(irq_req), 32'h0);
        rd(1'b1, r); check("R7 status", r, 32'hFFFF_FFFF);

        // R10 held presentation, then withdrawal
        pulse(13);
        check("R10 start", 32'(irq_vector), 32'h4D);
        pulse(0);
        check("R10 held", 32'(irq_vector), 32'h4D);
        wr(1'b0, 32'h2080); tick(1);
        check("R10 withdrawn", 32'(irq_req), 32'h0);
        tick(1);
        check("R10 next", 32'(irq_vector), 32'h40);
        ack(); wr(1'b0, 32'h0080); clean();

        // R11 pad latch write
        pad_latch_wr = 1'b1; pad_latch_en = 2'b00; tick(1); pad_latch_wr = 1'b0; tick(1);
        check("R11 no enable", 32'(irq_req), 32'h0);
        pad_latch_wr = 1'b1; pad_latch_en = 2'b10; tick(1); pad_latch_wr = 1'b0; tick(1);
        check("R11 port", 32'(irq_vector), 32'h48);
        ack(); tick(1);

        // R12 reserved bit
        pulse(14);
        check("R12 src", 32'(irq_req), 32'h0);
        wr(1'b1, 32'h4000); tick(1);
        rd(1'b1, r); check("R12 status", r, 32'hFFFF_FFFF);
        check("R12 req", 32'(irq_req), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule